// File: doc/BRIEF.md
# Inbound Port-Write Capture Unit

This block receives port-write packets from a link-side word stream and keeps one 16-word message at a time in a single-entry buffer. A packet that is accepted and complete sets the queue-full state and a queue-full interrupt flag. The buffer then stays occupied until software issues a clear-queue command. While the buffer is occupied, new port-writes are dropped and a discard flag is raised. A packet that is too short or too long raises a transaction-error flag instead of filling the buffer.

Software drives the unit through a mode register and a status register, both written over one simple write port. It reads the captured words back through a word-indexed read port. One interrupt output combines the queue-full interrupt and the transaction error, each gated by its own enable bit in the mode register. The error flag can only be cleared while the unit is disabled.

Top module: `pw_capture_unit`

## Requirements
- R1: After reset the mode register, the status register, every buffer word and `irq_o` all read 0.
- R2: Mode register fields: bit 20 snoop enable, bit 8 queue-full interrupt enable, bit 5 error interrupt enable, bit 1 clear-queue command, bit 0 unit enable. A mode write stores bits 20, 8, 5 and 0. Bit 1 is a self-clearing command and always reads 0.
- R3: A packet of exactly 16 beats that starts while the unit is enabled and the buffer is empty is stored in arrival order at word indices 0 to 15. The clock edge that takes its last beat sets status bit 20 (queue full) and bit 4 (queue-full interrupt).
- R4: Writing the mode register with bit 1 set clears queue full on that edge, unless a packet completes on the same edge. Bit 4 is not changed. The next packet is then accepted.
- R5: A packet whose first beat arrives while queue full is set is dropped as a whole. The buffer is left unchanged, and status bit 3 (discarded) is set on the edge that takes the first beat.
- R6: A packet whose first beat arrives while mode bit 0 is 0 is ignored as a whole. No status bit changes and no buffer word changes.
- R7: An accepted packet whose last beat is not its 16th beat sets status bit 7 (transaction error) and does not set queue full. Only its first 16 words are stored.
- R8: A status write with bit 7 set clears the transaction error only while mode bit 0 is 0. Otherwise the flag is kept.
- R9: Status bits 4 and 3 are write-1-to-clear. A set on the same edge wins over the clear. Writes to bits 20 and 2 have no effect.
- R10: Status bit 2 (busy) is 1 from the edge after the first beat of an accepted packet until the edge that takes its last beat.
- R11: `irq_o` is 1 exactly when (mode bit 8 and status bit 4) or (mode bit 5 and status bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pw_valid_i | input | 1 | Link beat valid |
| pw_data_i | input | 32 | Link beat payload word |
| pw_last_i | input | 1 | Marks the final beat of a packet |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 mode, 1 status |
| reg_wdata_i | input | 32 | Register write data |
| mode_o | output | 32 | Mode register readback |
| status_o | output | 32 | Status register readback |
| rd_idx_i | input | 4 | Buffer word index |
| rd_data_o | output | 32 | Buffer word at `rd_idx_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
Several conditions are hard to reach from the ports. One is an interrupt flag being cleared on the very edge a packet completes. Another is an error clear while the unit is still enabled, and a third is a packet arriving while the unit is disabled but the buffer is full. The stimulus is built from a per-cycle task that can drive a link beat and a register write on the same edge. This lets the bench place a write-1-to-clear exactly on the last beat, and toggle the enable bit between a short packet and its clear. A behavioural model in the bench tracks the flags, the packet state and the buffer contents, and it is compared with the outputs on every clock.

// File: rtl/pw_cap_pkg.sv
package pw_cap_pkg;
  // mode register bit positions
  localparam int unsigned MD_SNOOP = 20;
  localparam int unsigned MD_QFIE  = 8;
  localparam int unsigned MD_EIE   = 5;
  localparam int unsigned MD_CLRQ  = 1;
  localparam int unsigned MD_EN    = 0;
  // status register bit positions
  localparam int unsigned ST_QF    = 20;
  localparam int unsigned ST_TE    = 7;
  localparam int unsigned ST_QFI   = 4;
  localparam int unsigned ST_DISC  = 3;
  localparam int unsigned ST_BUSY  = 2;

  typedef enum logic [1:0] {
    PW_IGNORE  = 2'd0,
    PW_DROP    = 2'd1,
    PW_CAPTURE = 2'd2
  } pw_kind_e;
endpackage

// File: rtl/pw_rx_ctrl.sv
module pw_rx_ctrl
  import pw_cap_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MSG_WORDS = 16,
  localparam int unsigned IDX_W    = $clog2(MSG_WORDS),
  localparam int unsigned CNT_W    = $clog2(MSG_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pw_valid_i,
  input  logic [DATA_W-1:0] pw_data_i,
  input  logic              pw_last_i,
  input  logic              enable_i,
  input  logic              full_i,
  output logic              buf_we_o,
  output logic [IDX_W-1:0]  buf_idx_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  output logic              fill_o,
  output logic              err_o,
  output logic              drop_o,
  output logic              busy_o
);
  localparam logic [CNT_W-1:0] WORDS_C = CNT_W'(MSG_WORDS);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(MSG_WORDS - 1);

  logic             in_pkt_q, busy_q;
  pw_kind_e         kind_q, kind_cur;
  logic [CNT_W-1:0] cnt_q, cnt_cur;
  logic             start, cap_beat;

  assign start = pw_valid_i & ~in_pkt_q;

  // admission is decided once, on the first beat
  always_comb begin
    kind_cur = kind_q;
    cnt_cur  = cnt_q;
    if (start) begin
      cnt_cur = '0;
      if (!enable_i)   kind_cur = PW_IGNORE;
      else if (full_i) kind_cur = PW_DROP;
      else             kind_cur = PW_CAPTURE;
    end
  end

  assign cap_beat    = pw_valid_i & (kind_cur == PW_CAPTURE);
  assign buf_we_o    = cap_beat & (cnt_cur < WORDS_C);
  assign buf_idx_o   = cnt_cur[IDX_W-1:0];
  assign buf_wdata_o = pw_data_i;
  assign fill_o      = cap_beat & pw_last_i & (cnt_cur == LAST_C);
  assign err_o       = cap_beat & pw_last_i & (cnt_cur != LAST_C);
  assign drop_o      = start & (kind_cur == PW_DROP);
  assign busy_o      = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      busy_q   <= 1'b0;
      kind_q   <= PW_IGNORE;
      cnt_q    <= '0;
    end else if (pw_valid_i) begin
      in_pkt_q <= ~pw_last_i;
      busy_q   <= (kind_cur == PW_CAPTURE) & ~pw_last_i;
      kind_q   <= kind_cur;
      cnt_q    <= (cnt_cur == WORDS_C) ? cnt_cur : cnt_cur + CNT_W'(1);
    end
  end

  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && pw_valid_i && pw_last_i |=> !busy_q); // R10
endmodule

// File: rtl/pw_msg_buf.sv
module pw_msg_buf #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MSG_WORDS = 16,
  localparam int unsigned IDX_W    = $clog2(MSG_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [MSG_WORDS];

  for (genvar w = 0; w < MSG_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[w] <= '0;
      else if (we_i && widx_i == IDX_W'(w))  mem_q[w] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/pw_csr.sv
module pw_csr
  import pw_cap_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              fill_i,
  input  logic              err_i,
  input  logic              drop_i,
  input  logic              busy_i,
  output logic              enable_o,
  output logic              full_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic snoop_q, qfie_q, eie_q, en_q;
  logic qf_q, te_q, qfi_q, disc_q;
  logic mode_wr, stat_wr, clrq;
  logic unused_wdata;

  assign mode_wr = reg_we_i & ~reg_sel_i;
  assign stat_wr = reg_we_i &  reg_sel_i;
  assign clrq    = mode_wr & reg_wdata_i[MD_CLRQ];
  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snoop_q <= 1'b0;
      qfie_q  <= 1'b0;
      eie_q   <= 1'b0;
      en_q    <= 1'b0;
    end else if (mode_wr) begin
      snoop_q <= reg_wdata_i[MD_SNOOP];
      qfie_q  <= reg_wdata_i[MD_QFIE];
      eie_q   <= reg_wdata_i[MD_EIE];
      en_q    <= reg_wdata_i[MD_EN];
    end
  end

  // hardware set wins over software clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qf_q   <= 1'b0;
      te_q   <= 1'b0;
      qfi_q  <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      if (fill_i)    qf_q <= 1'b1;
      else if (clrq) qf_q <= 1'b0;

      if (fill_i)                                   qfi_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[ST_QFI])      qfi_q <= 1'b0;

      if (drop_i)                                   disc_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[ST_DISC])     disc_q <= 1'b0;

      if (err_i)                                    te_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[ST_TE] && !en_q) te_q <= 1'b0;
    end
  end

  always_comb begin
    mode_o           = '0;
    mode_o[MD_SNOOP] = snoop_q;
    mode_o[MD_QFIE]  = qfie_q;
    mode_o[MD_EIE]   = eie_q;
    mode_o[MD_EN]    = en_q;
    status_o          = '0;
    status_o[ST_QF]   = qf_q;
    status_o[ST_TE]   = te_q;
    status_o[ST_QFI]  = qfi_q;
    status_o[ST_DISC] = disc_q;
    status_o[ST_BUSY] = busy_i;
  end

  assign enable_o = en_q;
  assign full_o   = qf_q;
  assign irq_o    = (qfie_q & qfi_q) | (eie_q & te_q);

  AST_FILL_SETS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> qf_q && qfi_q); // R3
  AST_CLRQ_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clrq && !fill_i |=> !qf_q); // R4
  AST_DROP_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> disc_q); // R5
  AST_TE_HELD_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    te_q && en_q |=> te_q); // R8
endmodule

// File: rtl/pw_capture_unit.sv
module pw_capture_unit #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MSG_WORDS = 16,
  localparam int unsigned IDX_W    = $clog2(MSG_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pw_valid_i,
  input  logic [DATA_W-1:0] pw_data_i,
  input  logic              pw_last_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] status_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic              buf_we, fill, err, drop, busy, enable, full;
  logic [IDX_W-1:0]  buf_idx;
  logic [DATA_W-1:0] buf_wdata;

  pw_rx_ctrl #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pw_valid_i  (pw_valid_i),
    .pw_data_i   (pw_data_i),
    .pw_last_i   (pw_last_i),
    .enable_i    (enable),
    .full_i      (full),
    .buf_we_o    (buf_we),
    .buf_idx_o   (buf_idx),
    .buf_wdata_o (buf_wdata),
    .fill_o      (fill),
    .err_o       (err),
    .drop_o      (drop),
    .busy_o      (busy)
  );

  pw_msg_buf #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (buf_we),
    .widx_i  (buf_idx),
    .wdata_i (buf_wdata),
    .ridx_i  (rd_idx_i),
    .rdata_o (rd_data_o)
  );

  pw_csr #(.DATA_W(DATA_W)) u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .fill_i      (fill),
    .err_i       (err),
    .drop_i      (drop),
    .busy_i      (busy),
    .enable_o    (enable),
    .full_o      (full),
    .mode_o      (mode_o),
    .status_o    (status_o),
    .irq_o       (irq_o)
  );

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we |-> !full); // R5
  AST_IGNORED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable && pw_valid_i && !busy |-> !buf_we); // R6
endmodule

// File: tb/pw_capture_unit_bench.sv
module pw_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pw_valid = 1'b0, pw_last = 1'b0;
  logic [31:0] pw_data = '0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] mode, status, rd_data;
  logic        irq;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  pw_capture_unit u_pw_capture_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .pw_valid_i(pw_valid), .pw_data_i(pw_data), .pw_last_i(pw_last),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .mode_o(mode), .status_o(status),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit m_sen, m_qfie, m_eie, m_en;
  bit m_qf, m_te, m_qfi, m_disc, m_busy, m_in;
  int m_kind, m_cnt;
  logic [31:0] m_words [16];
  bit t_fill, t_err, t_drop, t_clrq;

  function automatic logic [31:0] exp_status();
    return (32'(m_qf) << 20) | (32'(m_te) << 7) | (32'(m_qfi) << 4) |
           (32'(m_disc) << 3) | (32'(m_busy) << 2);
  endfunction
  function automatic logic [31:0] exp_mode();
    return (32'(m_sen) << 20) | (32'(m_qfie) << 8) | (32'(m_eie) << 5) | 32'(m_en);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_sen, m_qfie, m_eie, m_en} = '0;
      {m_qf, m_te, m_qfi, m_disc, m_busy, m_in} = '0;
      m_kind = 0; m_cnt = 0;
      for (int i = 0; i < 16; i++) m_words[i] = '0;
    end else begin
      t_fill = 0; t_err = 0; t_drop = 0; t_clrq = 0;
      if (pw_valid) begin
        if (!m_in) begin
          m_cnt = 0;
          if (!m_en) m_kind = 0;
          else if (m_qf) begin m_kind = 1; t_drop = 1; end
          else m_kind = 2;
        end
        if (m_kind == 2) begin
          if (m_cnt < 16) m_words[m_cnt] = pw_data;
          if (pw_last) begin
            if (m_cnt == 15) t_fill = 1; else t_err = 1;
          end
        end
        m_busy = (m_kind == 2) && !pw_last;
        m_in = !pw_last;
        m_cnt++;
      end
      if (reg_we && reg_sel) begin
        if (reg_wdata[4]) m_qfi = 0;
        if (reg_wdata[3]) m_disc = 0;
        if (reg_wdata[7] && !m_en) m_te = 0;
      end
      if (reg_we && !reg_sel) begin
        m_sen = reg_wdata[20]; m_qfie = reg_wdata[8];
        m_eie = reg_wdata[5];  m_en = reg_wdata[0];
        t_clrq = reg_wdata[1];
      end
      if (t_clrq) m_qf = 0;
      if (t_fill) begin m_qf = 1; m_qfi = 1; end
      if (t_drop) m_disc = 1;
      if (t_err)  m_te = 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3/R5/R7/R9/R10 status", status, exp_status());
      chk("R2 mode", mode, exp_mode());
      chk("R11 irq", 32'(irq), 32'((m_qfie & m_qfi) | (m_eie & m_te)));
      chk("R3/R6 buffer word", rd_data, m_words[rd_idx]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL R1 watchdog act=%0d exp=finished", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input logic v, input logic [31:0] d, input logic l,
                     input logic we, input logic sel, input logic [31:0] wd);
    @(negedge clk); #1;
    pw_valid = v; pw_data = d; pw_last = l;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    rd_idx = rd_idx + 4'd1;
  endtask
  task automatic idle(); cyc(0, '0, 0, 0, 0, '0); endtask
  task automatic wr_mode(input logic [31:0] v);   cyc(0, '0, 0, 1, 0, v); idle(); endtask
  task automatic wr_status(input logic [31:0] v); cyc(0, '0, 0, 1, 1, v); idle(); endtask

  task automatic send(input int n, input logic [31:0] base, input bit chk_busy);
    for (int i = 0; i < n; i++) begin
      cyc(1, base + 32'(i), i == n - 1, 0, 0, '0);
      if (chk_busy && i == 1) chk("R10 busy mid-packet", status[2], 1);
    end
    idle();
  endtask

  task automatic read_word(input int i, input logic [31:0] exp, input string req);
    @(negedge clk); #1;
    rd_idx = 4'(i);
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset status", status, 0);
    chk("R1 reset irq", 32'(irq), 0);
    read_word(7, 0, "R1 reset buffer");
    #1; rst_n = 1'b1;
    idle();

    wr_mode(32'h0010_0123);
    chk("R2 mode readback, clear-queue reads 0", mode, 32'h0010_0121);

    send(16, 32'hA000_0000, 1);
    chk("R10 busy dropped after last", status[2], 0);
    chk("R3 full and qfi set", status, 32'h0010_0010);
    chk("R11 irq from qfi", 32'(irq), 1);
    read_word(0, 32'hA000_0000, "R3 word 0");
    read_word(15, 32'hA000_000F, "R3 word 15");

    send(16, 32'hC000_0000, 0);
    chk("R5 discard flag", status, 32'h0010_0018);
    read_word(3, 32'hA000_0003, "R5 buffer unchanged");

    wr_status(32'h0010_0018);
    chk("R9 w1c qfi/disc, full kept", status, 32'h0010_0000);
    chk("R11 irq low after clear", 32'(irq), 0);

    wr_mode(32'h0010_0123);
    chk("R4 clear-queue empties", status, 32'h0000_0000);
    send(16, 32'hB000_0000, 0);
    chk("R4 next packet accepted", status, 32'h0010_0010);
    read_word(9, 32'hB000_0009, "R4 new content");

    wr_status(32'h0000_0010);
    wr_mode(32'h0010_0120);
    send(16, 32'hD000_0000, 0);
    chk("R6 disabled: no status change", status, 32'h0010_0000);
    read_word(4, 32'hB000_0004, "R6 disabled: buffer unchanged");

    wr_mode(32'h0010_0123);
    send(5, 32'hE000_0000, 0);
    chk("R7 short packet error", status, 32'h0000_0080);
    chk("R11 irq from error", 32'(irq), 1);
    wr_status(32'h0000_0080);
    chk("R8 error kept while enabled", status, 32'h0000_0080);
    wr_mode(32'h0010_0120);
    wr_status(32'h0000_0080);
    chk("R8 error cleared while disabled", status, 0);

    wr_mode(32'h0010_0121);
    send(18, 32'h1000_0000, 0);
    chk("R7 long packet error", status, 32'h0000_0080);
    read_word(15, 32'h1000_000F, "R7 first 16 words kept");
    wr_mode(32'h0010_0120);
    wr_status(32'h0000_0080);
    wr_mode(32'h0010_0121);

    for (int i = 0; i < 15; i++) cyc(1, 32'h2000_0000 + 32'(i), 0, 0, 0, '0);
    cyc(1, 32'h2000_000F, 1, 1, 1, 32'h0010_0014);
    idle();
    chk("R9 set wins over same-edge clear", status, 32'h0010_0010);

    wr_mode(32'h0010_0021);
    chk("R11 irq masked by enable", 32'(irq), 0);

    repeat (2) idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule